// File: doc/BRIEF.md
# Power-up configuration select controller

This block decides, once per power-on reset, whether the clock chip runs under serial-bus control or under pin control, and it keeps the working register file loaded with the chosen configuration. A strap pin is sampled while reset is held. When the strap is high the chip is in pin-select mode: the two select pins pick one of four configurations held in a store. The controller copies that configuration into the working registers one word per cycle. When the strap is low the chip is in serial mode. The select pins then belong to the serial bus and the controller performs only the initial load.

In pin-select mode the controller keeps watching the select pins after power-up. A select change is taken only after a settling window measured from reset release. After an accepted change, further changes are held off for a lockout window. Every load, whether at power-up or after a select change, ends with a one-cycle synchronisation pulse that realigns the output dividers. A change in which both select bits flip at once is flagged and ignored.

Top module: `pcfg_select_ctrl`

## Requirements
- R1: The strap is sampled on every clock while `rst` is high. After reset `hw_mode_o` shows the sampled level (1 = pin-select mode) and does not change with later strap activity.
- R2: In pin-select mode with `load_en_i` = 1, the select value sampled during reset (0 to 3) picks the configuration loaded at power-up. `active_cfg_o` reports that value and `bus_en_o` is 0.
- R3: In serial mode with `load_en_i` = 1, the power-up load writes built-in defaults, where word n is 0xC0 XOR (5·n mod 256). `bus_en_o` is 1.
- R4: In serial mode with `load_en_i` = 0, the power-up load copies configuration 0 from the store.
- R5: In pin-select mode with `load_en_i` = 0, configuration 0 is loaded and the select pins never cause a reload.
- R6: Every load ends with exactly one single-cycle `sync_rst_o` pulse, after the last register write. `done_o` rises on the cycle that follows the pulse.
- R7: A select change is ignored until `SETTLE_CYC` cycles after reset release. A difference that is still present after that window is then loaded.
- R8: After an accepted select change, further changes are ignored for `HOLD_CYC` cycles. A difference still pending when the lockout ends is then loaded.
- R9: A select value that differs from the last accepted value in both bits produces one `sel_err_o` pulse and causes no reload and no change to `active_cfg_o`.
- R10: `done_o` is 0 during reset and from the start of each copy until the synchronisation pulse. The copy reads the store with one cycle of latency and writes addresses 0 to NREG-1 in ascending order.
- R11: In serial mode, select-pin activity never triggers a reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| strap_i | input | 1 | Mode strap, sampled during reset |
| sel_i | input | 2 | Configuration select pins (asynchronous) |
| load_en_i | input | 1 | Load-enable register bit |
| st_rd_en_o | output | 1 | Store read strobe |
| st_cfg_o | output | 2 | Store configuration index |
| st_addr_o | output | AW | Store word address |
| st_data_i | input | DW | Store read data, one cycle after the strobe |
| wr_en_o | output | 1 | Working-register write strobe |
| wr_addr_o | output | AW | Working-register address |
| wr_data_o | output | DW | Working-register write data |
| sync_rst_o | output | 1 | Output-divider synchronisation pulse |
| hw_mode_o | output | 1 | 1 = pin-select mode |
| bus_en_o | output | 1 | 1 = serial bus access enabled |
| done_o | output | 1 | Load complete, no copy running |
| active_cfg_o | output | 2 | Last accepted configuration index |
| sel_err_o | output | 1 | Pulse on a two-bit select change |

## Verification
The bench moves the select pins inside the settling window and inside the lockout window. A design that ignores either window would reload early, and the synchronisation pulse count and the mirrored register contents would expose it. It flips both select bits at once, where a wrong design would reload a configuration or miss the error pulse. It boots in each mode and load-enable combination. Loading store data instead of defaults, or letting the select pins reach the loader in serial mode, shows up as wrong register words or extra pulses. Strap activity after reset checks that the mode is latched only once.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;

    typedef enum logic {
        MODE_SW = 1'b0,
        MODE_HW = 1'b1
    } mode_e;

    typedef enum logic [1:0] {
        CP_IDLE  = 2'd0,
        CP_READ  = 2'd1,
        CP_FLUSH = 2'd2,
        CP_SYNC  = 2'd3
    } copy_st_e;

    typedef struct packed {
        logic [1:0] cfg;
        logic       use_dflt;
    } load_req_t;

    // built-in serial-mode default word for a register index
    function automatic logic [7:0] dflt_byte(logic [7:0] idx);
        return 8'hC0 ^ (idx * 8'd5);
    endfunction

    // exactly one select bit differs
    function automatic logic one_bit_step(logic [1:0] a, logic [1:0] b);
        return (a ^ b) == 2'b01 || (a ^ b) == 2'b10;
    endfunction

    function automatic logic two_bit_step(logic [1:0] a, logic [1:0] b);
        return (a ^ b) == 2'b11;
    endfunction

endpackage

// File: rtl/pcfg_sync2.sv
module pcfg_sync2 #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk) begin
        meta_q <= d_i;
        sync_q <= meta_q;
    end

    assign q_o = sync_q;
endmodule

// File: rtl/pcfg_copy_engine.sv
module pcfg_copy_engine
    import pcfg_pkg::*;
#(
    parameter int NREG = 8,
    parameter int DW   = 8,
    parameter int AW   = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  load_req_t     req_i,
    input  logic [DW-1:0] st_data_i,
    output logic          st_rd_en_o,
    output logic [1:0]    st_cfg_o,
    output logic [AW-1:0] st_addr_o,
    output logic          wr_en_o,
    output logic [AW-1:0] wr_addr_o,
    output logic [DW-1:0] wr_data_o,
    output logic          sync_o,
    output logic          busy_o,
    output logic          loaded_o
);
    localparam logic [AW-1:0] LAST = AW'(NREG - 1);

    copy_st_e      st_q;
    logic [AW-1:0] cnt_q;
    load_req_t     req_q;
    logic          rv_q;
    logic [AW-1:0] a_q;
    logic          loaded_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= CP_IDLE;
            cnt_q    <= '0;
            req_q    <= '0;
            rv_q     <= 1'b0;
            a_q      <= '0;
            loaded_q <= 1'b0;
        end else begin
            rv_q <= (st_q == CP_READ);
            a_q  <= cnt_q;
            case (st_q)
                CP_IDLE: begin
                    if (start_i) begin
                        st_q  <= CP_READ;
                        cnt_q <= '0;
                        req_q <= req_i;
                    end
                end
                CP_READ: begin
                    if (cnt_q == LAST) st_q <= CP_FLUSH;
                    else               cnt_q <= cnt_q + 1'b1;
                end
                CP_FLUSH: st_q <= CP_SYNC;
                CP_SYNC: begin
                    st_q     <= CP_IDLE;
                    loaded_q <= 1'b1;
                end
                default: st_q <= CP_IDLE;
            endcase
        end
    end

    logic [7:0] dflt_w;
    assign dflt_w = dflt_byte(8'(a_q));

    assign st_rd_en_o = (st_q == CP_READ) && !req_q.use_dflt;
    assign st_cfg_o   = req_q.cfg;
    assign st_addr_o  = cnt_q;
    assign wr_en_o    = rv_q;
    assign wr_addr_o  = a_q;
    assign wr_data_o  = req_q.use_dflt ? DW'(dflt_w) : st_data_i;
    assign sync_o     = (st_q == CP_SYNC);
    assign busy_o     = (st_q != CP_IDLE);
    assign loaded_o   = loaded_q;
endmodule

// File: rtl/pcfg_mode_ctrl.sv
module pcfg_mode_ctrl
    import pcfg_pkg::*;
#(
    parameter int SETTLE_CYC = 100000,
    parameter int HOLD_CYC   = 10000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       strap_i,
    input  logic [1:0] sel_raw_i,
    input  logic [1:0] sel_s_i,
    input  logic       load_en_i,
    input  logic       eng_busy_i,
    output logic       start_o,
    output load_req_t  req_o,
    output mode_e      mode_o,
    output logic [1:0] acc_o,
    output logic       err_o
);
    localparam int SCW = $clog2(SETTLE_CYC + 1);
    localparam int HCW = $clog2(HOLD_CYC + 1);

    mode_e          mode_q;
    logic [1:0]     sel_cap_q;
    logic           boot_q;
    logic [SCW-1:0] settle_q;
    logic [HCW-1:0] hold_q;
    logic [1:0]     acc_q;
    logic           err_q;
    logic           err_seen_q;

    logic settled, watch, accept, bad_step;

    assign settled  = (settle_q == SCW'(SETTLE_CYC));
    assign watch    = !boot_q && (mode_q == MODE_HW) && load_en_i && settled
                      && (hold_q == '0) && !eng_busy_i;
    assign accept   = watch && one_bit_step(sel_s_i, acc_q);
    assign bad_step = watch && two_bit_step(sel_s_i, acc_q);

    always_comb begin
        req_o = '0;
        if (boot_q) begin
            if (mode_q == MODE_HW) begin
                req_o.cfg = load_en_i ? sel_cap_q : 2'd0;
            end else begin
                req_o.use_dflt = load_en_i;
            end
        end else begin
            req_o.cfg = sel_s_i;
        end
    end

    assign start_o = boot_q || accept;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q     <= strap_i ? MODE_HW : MODE_SW;
            sel_cap_q  <= sel_raw_i;
            boot_q     <= 1'b1;
            settle_q   <= '0;
            hold_q     <= '0;
            acc_q      <= '0;
            err_q      <= 1'b0;
            err_seen_q <= 1'b0;
        end else begin
            boot_q <= 1'b0;
            if (!settled) settle_q <= settle_q + 1'b1;
            if (start_o) begin
                acc_q <= req_o.cfg;
            end
            if (accept)            hold_q <= HCW'(HOLD_CYC);
            else if (hold_q != '0) hold_q <= hold_q - 1'b1;
            err_q <= bad_step && !err_seen_q;
            if (!two_bit_step(sel_s_i, acc_q)) err_seen_q <= 1'b0;
            else if (bad_step)                 err_seen_q <= 1'b1;
        end
    end

    assign mode_o = mode_q;
    assign acc_o  = acc_q;
    assign err_o  = err_q;
endmodule

// File: rtl/pcfg_select_ctrl.sv
module pcfg_select_ctrl
    import pcfg_pkg::*;
#(
    parameter int NREG       = 8,
    parameter int DW         = 8,
    parameter int SETTLE_CYC = 100000,
    parameter int HOLD_CYC   = 10000,
    localparam int AW        = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          strap_i,
    input  logic [1:0]    sel_i,
    input  logic          load_en_i,
    output logic          st_rd_en_o,
    output logic [1:0]    st_cfg_o,
    output logic [AW-1:0] st_addr_o,
    input  logic [DW-1:0] st_data_i,
    output logic          wr_en_o,
    output logic [AW-1:0] wr_addr_o,
    output logic [DW-1:0] wr_data_o,
    output logic          sync_rst_o,
    output logic          hw_mode_o,
    output logic          bus_en_o,
    output logic          done_o,
    output logic [1:0]    active_cfg_o,
    output logic          sel_err_o
);
    logic [1:0] sel_s;
    logic       start;
    load_req_t  req;
    mode_e      mode;
    logic       busy, loaded;

    pcfg_sync2 #(.W(2)) u_sync (
        .clk (clk),
        .d_i (sel_i),
        .q_o (sel_s)
    );

    pcfg_mode_ctrl #(
        .SETTLE_CYC (SETTLE_CYC),
        .HOLD_CYC   (HOLD_CYC)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .strap_i    (strap_i),
        .sel_raw_i  (sel_i),
        .sel_s_i    (sel_s),
        .load_en_i  (load_en_i),
        .eng_busy_i (busy),
        .start_o    (start),
        .req_o      (req),
        .mode_o     (mode),
        .acc_o      (active_cfg_o),
        .err_o      (sel_err_o)
    );

    pcfg_copy_engine #(
        .NREG (NREG),
        .DW   (DW),
        .AW   (AW)
    ) u_copy (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start),
        .req_i      (req),
        .st_data_i  (st_data_i),
        .st_rd_en_o (st_rd_en_o),
        .st_cfg_o   (st_cfg_o),
        .st_addr_o  (st_addr_o),
        .wr_en_o    (wr_en_o),
        .wr_addr_o  (wr_addr_o),
        .wr_data_o  (wr_data_o),
        .sync_o     (sync_rst_o),
        .busy_o     (busy),
        .loaded_o   (loaded)
    );

    assign hw_mode_o = (mode == MODE_HW);
    assign bus_en_o  = (mode == MODE_SW);
    assign done_o    = loaded && !busy;
endmodule

// File: rtl/pcfg_select_ctrl_chk.sv
module pcfg_select_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en_o,
    input logic       st_rd_en_o,
    input logic       sync_rst_o,
    input logic       hw_mode_o,
    input logic       done_o,
    input logic [1:0] active_cfg_o,
    input logic       sel_err_o
);
    a_r1_mode_held: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(hw_mode_o));

    a_r6_sync_single: assert property (@(posedge clk) disable iff (rst)
        sync_rst_o |=> !sync_rst_o);

    a_r6_sync_then_done: assert property (@(posedge clk) disable iff (rst)
        sync_rst_o |=> done_o);

    a_r10_write_not_done: assert property (@(posedge clk) disable iff (rst)
        (wr_en_o || st_rd_en_o) |-> !done_o);

    a_r8_switch_drops_done: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$stable(active_cfg_o)) |-> !done_o);

    a_r9_err_while_idle: assert property (@(posedge clk) disable iff (rst)
        sel_err_o |-> done_o);
endmodule

bind pcfg_select_ctrl pcfg_select_ctrl_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_en_o      (wr_en_o),
    .st_rd_en_o   (st_rd_en_o),
    .sync_rst_o   (sync_rst_o),
    .hw_mode_o    (hw_mode_o),
    .done_o       (done_o),
    .active_cfg_o (active_cfg_o),
    .sel_err_o    (sel_err_o)
);

// File: tb/pcfg_select_ctrl_tb.sv
module pcfg_select_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NREG       = 4;
    localparam int DW         = 8;
    localparam int AW         = 2;
    localparam int SETTLE     = 200;
    localparam int HOLD       = 40;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          strap_i = 1'b1;
    logic [1:0]    sel_i = 2'd0;
    logic          load_en_i = 1'b1;
    logic          st_rd_en_o;
    logic [1:0]    st_cfg_o;
    logic [AW-1:0] st_addr_o;
    logic [DW-1:0] st_data_i;
    logic          wr_en_o;
    logic [AW-1:0] wr_addr_o;
    logic [DW-1:0] wr_data_o;
    logic          sync_rst_o, hw_mode_o, bus_en_o, done_o, sel_err_o;
    logic [1:0]    active_cfg_o;

    int errors = 0;
    int checks = 0;
    int sync_cnt = 0;
    int err_cnt = 0;
    logic [DW-1:0] wreg [NREG];

    always #(CLK_PERIOD/2) clk = ~clk;

    pcfg_select_ctrl #(
        .NREG(NREG), .DW(DW), .SETTLE_CYC(SETTLE), .HOLD_CYC(HOLD)
    ) u_dut (
        .clk(clk), .rst(rst), .strap_i(strap_i), .sel_i(sel_i),
        .load_en_i(load_en_i), .st_rd_en_o(st_rd_en_o), .st_cfg_o(st_cfg_o),
        .st_addr_o(st_addr_o), .st_data_i(st_data_i), .wr_en_o(wr_en_o),
        .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .sync_rst_o(sync_rst_o),
        .hw_mode_o(hw_mode_o), .bus_en_o(bus_en_o), .done_o(done_o),
        .active_cfg_o(active_cfg_o), .sel_err_o(sel_err_o)
    );

    function automatic logic [7:0] store_word(int c, int a);
        return 8'(8'h30 + c * 16 + a * 3);
    endfunction

    function automatic logic [7:0] dflt_word(int a);
        return 8'(8'hC0 ^ ((a * 5) % 256));
    endfunction

    // store model with one cycle read latency, and the working-register mirror
    always @(posedge clk) begin
        if (st_rd_en_o) st_data_i <= store_word(int'(st_cfg_o), int'(st_addr_o));
        if (rst) begin
            sync_cnt <= 0;
            err_cnt  <= 0;
            for (int i = 0; i < NREG; i++) wreg[i] <= '0;
        end else begin
            if (sync_rst_o) sync_cnt <= sync_cnt + 1;
            if (sel_err_o)  err_cnt  <= err_cnt + 1;
            if (wr_en_o)    wreg[wr_addr_o] <= wr_data_o;
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // cfg 4 selects the built-in defaults
    task automatic check_regs(string req, int cfg);
        for (int i = 0; i < NREG; i++) begin
            check(req, int'(wreg[i]), cfg == 4 ? int'(dflt_word(i)) : int'(store_word(cfg, i)));
        end
    endtask

    task automatic boot(logic strap, logic [1:0] sel, logic len);
        @(negedge clk);
        rst = 1'b1;
        strap_i = strap;
        sel_i = sel;
        load_en_i = len;
        step(4);
        check("R10 reset done", int'(done_o), 0);
        check("R6 reset sync", int'(sync_rst_o), 0);
        rst = 1'b0;
        step(1);
        check("R10 copy done low", int'(done_o), 0);
        step(20);
    endtask

    logic finished = 1'b0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int exp_sync;
        int exp_err;
        logic [1:0] acc;
        void'($urandom(32'd4711));

        // R2 pin-select boot with config 2
        boot(1'b1, 2'd2, 1'b1);
        check_regs("R2 boot regs", 2);
        check("R2 active", int'(active_cfg_o), 2);
        check("R2 bus off", int'(bus_en_o), 0);
        check("R1 mode hw", int'(hw_mode_o), 1);
        check("R6 one pulse", sync_cnt, 1);
        check("R6 done", int'(done_o), 1);
        strap_i = 1'b0;
        step(5);
        check("R1 strap ignored", int'(hw_mode_o), 1);

        // R7 change inside the settling window
        sel_i = 2'd3;
        step(60);
        check("R7 early ignored", int'(active_cfg_o), 2);
        check("R7 no pulse", sync_cnt, 1);
        step(200);
        check("R7 late taken", int'(active_cfg_o), 3);
        check_regs("R7 regs", 3);
        check("R7 pulse", sync_cnt, 2);

        // R8 lockout after a switch
        sel_i = 2'd1;
        step(15);
        check("R8 first", int'(active_cfg_o), 1);
        check_regs("R8 regs", 1);
        sel_i = 2'd0;
        step(10);
        check("R8 held", int'(active_cfg_o), 1);
        check("R8 held pulse", sync_cnt, 3);
        step(60);
        check("R8 after", int'(active_cfg_o), 0);
        check_regs("R8 regs after", 0);
        check("R8 pulse", sync_cnt, 4);

        // R9 two-bit change
        sel_i = 2'd3;
        step(20);
        check("R9 err", err_cnt, 1);
        check("R9 active", int'(active_cfg_o), 0);
        check("R9 no pulse", sync_cnt, 4);
        sel_i = 2'd0;
        step(10);

        // random walk of select changes
        acc = 2'd0;
        exp_sync = 4;
        exp_err = 1;
        for (int it = 0; it < 16; it++) begin
            int r = int'($urandom % 4);
            if (r == 0) begin
                sel_i = ~acc;
                exp_err++;
                step(20);
                check("R9 rand err", err_cnt, exp_err);
                sel_i = acc;
                step(10);
            end else begin
                acc = acc ^ (r == 1 ? 2'b01 : 2'b10);
                sel_i = acc;
                exp_sync++;
                step(HOLD + 20);
            end
            check("R8 rand active", int'(active_cfg_o), int'(acc));
            check("R6 rand pulses", sync_cnt, exp_sync);
            check_regs("R10 rand regs", int'(acc));
        end

        // R3 serial mode with defaults, R11 pins ignored
        boot(1'b0, 2'd1, 1'b1);
        check_regs("R3 defaults", 4);
        check("R3 bus on", int'(bus_en_o), 1);
        check("R1 mode sw", int'(hw_mode_o), 0);
        check("R6 sw pulse", sync_cnt, 1);
        step(250);
        sel_i = 2'd0;
        step(50);
        check("R11 no reload", sync_cnt, 1);
        check_regs("R11 regs", 4);

        // R4 serial mode, load-enable clear
        boot(1'b0, 2'd2, 1'b0);
        check_regs("R4 cfg0", 0);

        // R5 pin-select, load-enable clear
        boot(1'b1, 2'd3, 1'b0);
        check_regs("R5 cfg0", 0);
        check("R5 active", int'(active_cfg_o), 0);
        step(250);
        sel_i = 2'd2;
        step(60);
        check("R5 pins ignored", sync_cnt, 1);
        check("R5 active kept", int'(active_cfg_o), 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule